// File: doc/BRIEF.md
# Segment-Relative Address Translator

This unit turns a segment-relative memory reference into a flat 32-bit address. It keeps six segment registers, each holding a 16-bit selector together with a cached base, limit and type code. A requester presents an access kind, an optional explicit segment choice, a 32-bit offset and a write flag. The unit picks the segment, checks the offset against the limit and checks the access against the type code. It then adds the base to the offset. No paging stage follows, so the sum is the physical address.

Segment registers are written through a separate load port. The port supplies the selector and the descriptor fields that were already decoded, so the unit never reads descriptor tables itself. If every base is zero and every limit is at its maximum, the translation is an identity map.

A small result machine registers every answer and presents it one cycle after the request. It has three states. RS_IDLE means no request was made in the previous cycle. RS_PASS means an address is presented. RS_FAULT means the previous request was refused. Each cycle it takes one of three transitions, whatever state it is in: no request goes to RS_IDLE, an allowed request goes to RS_PASS, and a refused request goes to RS_FAULT.

Top module: `seg_xlat_unit`

## Requirements
- R1: With no override, the access kind picks the segment. Kind 0 (fetch) uses CS, kind 1 (stack) uses SS, and kinds 2 and 3 (data) use DS.
- R2: When `req_ovr_en` is high, `req_ovr_seg` names the segment, with index 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS. Index 6 or 7 always faults.
- R3: An allowed access yields `phys_addr` = base + offset, wrapped modulo 2^32.
- R4: An offset strictly greater than the segment's limit faults. An offset equal to the limit is allowed.
- R5: A write (`req_write` high) through a segment whose type is 0xA (code) faults. Reads through any type are allowed by the type check.
- R6: A fetch (kind 0) faults unless the segment's type is 0xA, so a fetch through type 0x2 (data) faults.
- R7: A segment whose selector has bits 15..2 all zero is null. Loading it is allowed, and every access through it faults.
- R8: The answer to a request appears exactly one cycle later. A cycle with `req_valid` low gives `addr_valid` and `fault` both low in the next cycle.
- R9: `addr_valid` and `fault` are never high together, and `phys_addr` is zero whenever `addr_valid` is low.
- R10: With `ld_en` high and `ld_seg` below 6, the selector, base, limit and type of that segment are replaced at the clock edge. A request in the same cycle still sees the old fields. `ld_seg` 6 or 7 changes nothing.
- R11: After reset every segment holds selector 0, base 0, limit 0 and type 0, and both `addr_valid` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write a segment register this cycle |
| ld_seg | input | 3 | Segment index to write |
| ld_sel | input | 16 | Selector value |
| ld_base | input | 32 | Decoded segment base |
| ld_limit | input | 32 | Decoded segment limit (largest legal offset) |
| ld_type | input | 4 | Decoded segment type code |
| req_valid | input | 1 | Translation request |
| req_kind | input | 2 | Access kind: 0 fetch, 1 stack, 2/3 data |
| req_ovr_en | input | 1 | Use explicit segment instead of default |
| req_ovr_seg | input | 3 | Explicit segment index |
| req_offset | input | 32 | Offset within segment |
| req_write | input | 1 | Access is a write |
| addr_valid | output | 1 | Translated address presented |
| phys_addr | output | 32 | Physical address, zero unless valid |
| fault | output | 1 | Previous request refused |

## Verification
Directed vectors come first. The worked cases use a base of 0x50000 with a limit of 0xFFFF and probe offsets 0, 0x67, 0xFFFF and 0x10000. They separate a limit compare that is off by one from a correct one. Writes and fetches through code and data segments tell each type rule apart. Overrides to every index, including 6 and 7, show whether the default mapping leaks into explicit choices. A wrapping base, a null selector that carries only its low bits, and a load in the same cycle as a request each isolate one rule. Seeded random loads and requests then mix all kinds, overrides, types, null selectors and offsets on both sides of the limit. This exposes wrong priority between the checks.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;

    localparam int SEG_COUNT = 6;
    localparam int SEL_W     = 16;
    localparam int ADDR_W    = 32;
    localparam int TYPE_W    = 4;

    typedef enum logic [1:0] {
        KIND_FETCH    = 2'd0,
        KIND_STACK    = 2'd1,
        KIND_DATA     = 2'd2,
        KIND_DATA_ALT = 2'd3
    } acc_kind_e;

    // Segment register indices, shared by the load port and the override field
    localparam logic [2:0] SEG_ES = 3'd0;
    localparam logic [2:0] SEG_CS = 3'd1;
    localparam logic [2:0] SEG_SS = 3'd2;
    localparam logic [2:0] SEG_DS = 3'd3;
    localparam logic [2:0] SEG_FS = 3'd4;
    localparam logic [2:0] SEG_GS = 3'd5;

    localparam logic [3:0] TYPE_DATA_RW = 4'h2;
    localparam logic [3:0] TYPE_CODE_RX = 4'hA;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_PASS  = 2'd1,
        RS_FAULT = 2'd2
    } res_state_e;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter  int NSEG   = 6,
    parameter  int SEL_W  = 16,
    parameter  int ADDR_W = 32,
    parameter  int TYPE_W = 4,
    localparam int IDX_W  = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_limit,
    input  logic [TYPE_W-1:0] wr_type,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_ok,
    output logic [SEL_W-1:0]  rd_sel,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W-1:0] rd_limit,
    output logic [TYPE_W-1:0] rd_type
);

    logic [SEL_W-1:0]  sel_q   [NSEG];
    logic [ADDR_W-1:0] base_q  [NSEG];
    logic [ADDR_W-1:0] limit_q [NSEG];
    logic [TYPE_W-1:0] type_q  [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[g]   <= '0;
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                type_q[g]  <= '0;
            end else if (hit) begin
                sel_q[g]   <= wr_sel;
                base_q[g]  <= wr_base;
                limit_q[g] <= wr_limit;
                type_q[g]  <= wr_type;
            end
        end
    end

    assign rd_ok = ({1'b0, rd_idx} < (IDX_W+1)'(NSEG));

    always_comb begin
        rd_sel   = '0;
        rd_base  = '0;
        rd_limit = '0;
        rd_type  = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_sel   = sel_q[i];
                rd_base  = base_q[i];
                rd_limit = limit_q[i];
                rd_type  = type_q[i];
            end
        end
    end

endmodule

// File: rtl/seg_select.sv
module seg_select
    import segxlat_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [1:0]       kind,
    input  logic             ovr_en,
    input  logic [IDX_W-1:0] ovr_idx,
    output logic [IDX_W-1:0] seg_idx
);

    logic [IDX_W-1:0] dflt_idx;

    always_comb begin
        unique case (acc_kind_e'(kind))
            KIND_FETCH:    dflt_idx = IDX_W'(SEG_CS);
            KIND_STACK:    dflt_idx = IDX_W'(SEG_SS);
            KIND_DATA,
            KIND_DATA_ALT: dflt_idx = IDX_W'(SEG_DS);
            default:       dflt_idx = IDX_W'(SEG_DS);
        endcase
    end

    assign seg_idx = ovr_en ? ovr_idx : dflt_idx;

endmodule

// File: rtl/seg_check.sv
module seg_check
    import segxlat_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32,
    parameter int TYPE_W = 4
) (
    input  logic [1:0]        kind,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] offset,
    input  logic              seg_ok,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [TYPE_W-1:0] typ,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              deny
);

    logic is_null;
    logic over_limit;
    logic is_code;
    logic bad_write;
    logic bad_fetch;

    // Null: table index and table-select bits all clear; privilege bits ignored
    assign is_null    = (sel[SEL_W-1:2] == '0);
    assign over_limit = (offset > limit);
    assign is_code    = (typ == TYPE_W'(TYPE_CODE_RX));
    assign bad_write  = is_write && is_code;
    assign bad_fetch  = (kind == KIND_FETCH) && !is_code;

    assign deny     = !seg_ok || is_null || over_limit || bad_write || bad_fetch;
    assign lin_addr = base + offset;

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import segxlat_pkg::*;
#(
    parameter  int NSEG   = SEG_COUNT,
    parameter  int SW     = SEL_W,
    parameter  int AW     = ADDR_W,
    parameter  int TW     = TYPE_W,
    localparam int IDX_W  = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_seg,
    input  logic [SW-1:0]    ld_sel,
    input  logic [AW-1:0]    ld_base,
    input  logic [AW-1:0]    ld_limit,
    input  logic [TW-1:0]    ld_type,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_ovr_en,
    input  logic [IDX_W-1:0] req_ovr_seg,
    input  logic [AW-1:0]    req_offset,
    input  logic             req_write,
    output logic             addr_valid,
    output logic [AW-1:0]    phys_addr,
    output logic             fault
);

    logic [IDX_W-1:0] seg_idx;
    logic             seg_ok;
    logic [SW-1:0]    rd_sel;
    logic [AW-1:0]    rd_base;
    logic [AW-1:0]    rd_limit;
    logic [TW-1:0]    rd_type;
    logic [AW-1:0]    lin_addr;
    logic             deny;

    res_state_e       state_q;
    res_state_e       state_nx;
    logic [AW-1:0]    addr_q;

    seg_select #(.IDX_W(IDX_W)) u_select (
        .kind    (req_kind),
        .ovr_en  (req_ovr_en),
        .ovr_idx (req_ovr_seg),
        .seg_idx (seg_idx)
    );

    seg_regfile #(
        .NSEG   (NSEG),
        .SEL_W  (SW),
        .ADDR_W (AW),
        .TYPE_W (TW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ld_en),
        .wr_idx   (ld_seg),
        .wr_sel   (ld_sel),
        .wr_base  (ld_base),
        .wr_limit (ld_limit),
        .wr_type  (ld_type),
        .rd_idx   (seg_idx),
        .rd_ok    (seg_ok),
        .rd_sel   (rd_sel),
        .rd_base  (rd_base),
        .rd_limit (rd_limit),
        .rd_type  (rd_type)
    );

    seg_check #(
        .SEL_W  (SW),
        .ADDR_W (AW),
        .TYPE_W (TW)
    ) u_check (
        .kind     (req_kind),
        .is_write (req_write),
        .offset   (req_offset),
        .seg_ok   (seg_ok),
        .sel      (rd_sel),
        .base     (rd_base),
        .limit    (rd_limit),
        .typ      (rd_type),
        .lin_addr (lin_addr),
        .deny     (deny)
    );

    // Next-state: same three transitions from every state
    always_comb begin
        state_nx = RS_IDLE;
        unique case (state_q)
            RS_IDLE, RS_PASS, RS_FAULT: begin
                if (req_valid) state_nx = deny ? RS_FAULT : RS_PASS;
                else           state_nx = RS_IDLE;
            end
            default: state_nx = RS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 addr_q <= '0;
        else if (req_valid && !deny) addr_q <= lin_addr;
    end

    // Outputs decoded from state
    always_comb begin
        addr_valid = 1'b0;
        fault      = 1'b0;
        phys_addr  = '0;
        unique case (state_q)
            RS_IDLE:  ;
            RS_PASS: begin
                addr_valid = 1'b1;
                phys_addr  = addr_q;
            end
            RS_FAULT: fault = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk
    import segxlat_pkg::*;
#(
    parameter int SW = 16,
    parameter int AW = 32,
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_kind,
    input logic          req_write,
    input logic [AW-1:0] req_offset,
    input logic          seg_ok,
    input logic [SW-1:0] rd_sel,
    input logic [AW-1:0] rd_base,
    input logic [AW-1:0] rd_limit,
    input logic [TW-1:0] rd_type,
    input logic          addr_valid,
    input logic [AW-1:0] phys_addr,
    input logic          fault
);

    a_r2_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !seg_ok) |=> fault);

    a_r3_sum: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (phys_addr == $past(rd_base + req_offset)));

    a_r4_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seg_ok && (req_offset > rd_limit)) |=> fault);

    a_r5_code_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (rd_type == TW'(TYPE_CODE_RX))) |=> fault);

    a_r6_fetch_type: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == 2'd0) && (rd_type != TW'(TYPE_CODE_RX))) |=> fault);

    a_r7_null: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (rd_sel[SW-1:2] == '0)) |=> fault);

    a_r8_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (addr_valid || fault));

    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && !fault));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && fault));

    a_r9_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (phys_addr == '0));

endmodule

bind seg_xlat_unit seg_xlat_chk #(.SW(SW), .AW(AW), .TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_write  (req_write),
    .req_offset (req_offset),
    .seg_ok     (seg_ok),
    .rd_sel     (rd_sel),
    .rd_base    (rd_base),
    .rd_limit   (rd_limit),
    .rd_type    (rd_type),
    .addr_valid (addr_valid),
    .phys_addr  (phys_addr),
    .fault      (fault)
);

// File: tb/tb_seg_xlat_unit.sv
module tb_seg_xlat_unit;
    import segxlat_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_en;
    logic [2:0]  ld_seg;
    logic [15:0] ld_sel;
    logic [31:0] ld_base;
    logic [31:0] ld_limit;
    logic [3:0]  ld_type;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic        req_ovr_en;
    logic [2:0]  req_ovr_seg;
    logic [31:0] req_offset;
    logic        req_write;
    logic        addr_valid;
    logic [31:0] phys_addr;
    logic        fault;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] m_sel   [6];
    logic [31:0] m_base  [6];
    logic [31:0] m_limit [6];
    logic [3:0]  m_type  [6];

    always #10 clk = ~clk;  // 50 MHz

    seg_xlat_unit dut (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_base(ld_base),
        .ld_limit(ld_limit), .ld_type(ld_type),
        .req_valid(req_valid), .req_kind(req_kind), .req_ovr_en(req_ovr_en),
        .req_ovr_seg(req_ovr_seg), .req_offset(req_offset), .req_write(req_write),
        .addr_valid(addr_valid), .phys_addr(phys_addr), .fault(fault)
    );

    function automatic logic [2:0] seg_of(logic [1:0] k, logic ov, logic [2:0] oi);
        if (ov) return oi;
        if (k == 2'd0) return SEG_CS;
        if (k == 2'd1) return SEG_SS;
        return SEG_DS;
    endfunction

    // Returns {pass, address}
    function automatic logic [32:0] model(logic [1:0] k, logic ov, logic [2:0] oi,
                                          logic [31:0] off, logic wr);
        logic [2:0] s;
        s = seg_of(k, ov, oi);
        if (s > 3'd5) return 33'd0;
        if (m_sel[s][15:2] == 14'd0) return 33'd0;
        if (off > m_limit[s]) return 33'd0;
        if (wr && m_type[s] == 4'hA) return 33'd0;
        if (k == 2'd0 && m_type[s] != 4'hA) return 33'd0;
        return {1'b1, m_base[s] + off};
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(logic lv, logic [2:0] ls, logic [15:0] lsel, logic [31:0] lb,
                        logic [31:0] ll, logic [3:0] lt,
                        logic rv, logic [1:0] rk, logic ro, logic [2:0] roi,
                        logic [31:0] roff, logic rw, string tag);
        logic [32:0] e;
        e = rv ? model(rk, ro, roi, roff, rw) : 33'd0;
        ld_en = lv; ld_seg = ls; ld_sel = lsel; ld_base = lb; ld_limit = ll; ld_type = lt;
        req_valid = rv; req_kind = rk; req_ovr_en = ro; req_ovr_seg = roi;
        req_offset = roff; req_write = rw;
        @(posedge clk);
        @(negedge clk);
        if (lv && ls < 3'd6) begin
            m_sel[ls] = lsel; m_base[ls] = lb; m_limit[ls] = ll; m_type[ls] = lt;
        end
        chk(addr_valid == (rv && e[32]), tag, "addr_valid", 32'(addr_valid), 32'(rv && e[32]));
        chk(fault == (rv && !e[32]), tag, "fault", 32'(fault), 32'(rv && !e[32]));
        chk(phys_addr == ((rv && e[32]) ? e[31:0] : 32'd0), tag, "phys_addr",
            phys_addr, (rv && e[32]) ? e[31:0] : 32'd0);
    endtask

    task automatic load(logic [2:0] s, logic [15:0] sel, logic [31:0] b,
                        logic [31:0] l, logic [3:0] t, string tag);
        step(1'b1, s, sel, b, l, t, 1'b0, 2'd0, 1'b0, 3'd0, 32'd0, 1'b0, tag);
    endtask

    task automatic acc(logic [1:0] k, logic ov, logic [2:0] oi, logic [31:0] off,
                       logic wr, string tag);
        step(1'b0, 3'd0, 16'd0, 32'd0, 32'd0, 4'd0, 1'b1, k, ov, oi, off, wr, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5E6A11));
        for (int i = 0; i < 6; i++) begin
            m_sel[i] = '0; m_base[i] = '0; m_limit[i] = '0; m_type[i] = '0;
        end
        rst_n = 1'b0;
        ld_en = 0; ld_seg = 0; ld_sel = 0; ld_base = 0; ld_limit = 0; ld_type = 0;
        req_valid = 0; req_kind = 0; req_ovr_en = 0; req_ovr_seg = 0;
        req_offset = 0; req_write = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state of outputs
        chk(!addr_valid && !fault, "R11", "outputs after reset", {30'd0, addr_valid, fault}, 32'd0);
        // R11: every segment null with zero limit after reset
        acc(2'd2, 1'b0, 3'd0, 32'd0, 1'b0, "R11");
        acc(2'd1, 1'b1, SEG_GS, 32'd0, 1'b0, "R11");

        // R4 / R3: base 0x50000 limit 0xFFFF
        load(SEG_DS, 16'h0010, 32'h0005_0000, 32'h0000_FFFF, 4'h2, "R10");
        acc(2'd2, 1'b0, 3'd0, 32'h0, 1'b0, "R3");
        acc(2'd2, 1'b0, 3'd0, 32'h67, 1'b1, "R3");
        acc(2'd3, 1'b0, 3'd0, 32'hFFFF, 1'b0, "R4");
        acc(2'd2, 1'b0, 3'd0, 32'h1_0000, 1'b0, "R4");

        // R1 / R6 / R5 with code segment
        load(SEG_CS, 16'h0008, 32'h0, 32'hFFFF_FFFF, 4'hA, "R10");
        acc(2'd0, 1'b0, 3'd0, 32'h100, 1'b0, "R1");
        acc(2'd2, 1'b1, SEG_CS, 32'h200, 1'b1, "R5");
        acc(2'd2, 1'b1, SEG_CS, 32'h200, 1'b0, "R5");
        acc(2'd0, 1'b1, SEG_DS, 32'h10, 1'b0, "R6");

        // R1 stack default
        load(SEG_SS, 16'h0010, 32'h0000_1000, 32'h0000_0FFF, 4'h2, "R10");
        acc(2'd1, 1'b0, 3'd0, 32'hFFC, 1'b1, "R1");
        acc(2'd1, 1'b0, 3'd0, 32'h1000, 1'b1, "R4");

        // R7: selector with only privilege bits set is null
        load(SEG_ES, 16'h0003, 32'h0, 32'hFFFF_FFFF, 4'h2, "R10");
        acc(2'd2, 1'b1, SEG_ES, 32'h4, 1'b0, "R7");

        // R3: identity map and wrap
        load(SEG_DS, 16'h0010, 32'h0, 32'hFFFF_FFFF, 4'h2, "R10");
        acc(2'd2, 1'b0, 3'd0, 32'h000B_8000, 1'b1, "R3");
        load(SEG_FS, 16'h0018, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 4'h2, "R10");
        acc(2'd2, 1'b1, SEG_FS, 32'h20, 1'b0, "R3");

        // R2: bad override indices
        acc(2'd2, 1'b1, 3'd6, 32'h0, 1'b0, "R2");
        acc(2'd2, 1'b1, 3'd7, 32'h0, 1'b0, "R2");

        // R10: same-cycle load and request sees old fields; index 7 ignored
        step(1'b1, SEG_GS, 16'h0020, 32'h100, 32'hFF, 4'h2,
             1'b1, 2'd2, 1'b1, SEG_GS, 32'h4, 1'b0, "R10");
        acc(2'd2, 1'b1, SEG_GS, 32'h4, 1'b0, "R10");
        load(3'd7, 16'h0000, 32'h0, 32'h0, 4'h0, "R10");
        acc(2'd2, 1'b0, 3'd0, 32'h1234, 1'b0, "R10");

        // R8: idle cycle
        step(1'b0, 3'd0, 16'd0, 32'd0, 32'd0, 4'd0, 1'b0, 2'd0, 1'b0, 3'd0, 32'd0, 1'b0, "R8");

        // Random mix (R1..R10, R9 on every vector)
        for (int n = 0; n < 4000; n++) begin
            logic        lv, rv, ro, rw;
            logic [2:0]  ls, oi, s;
            logic [15:0] lsel;
            logic [31:0] lb, ll, off;
            logic [3:0]  lt;
            logic [1:0]  rk;
            lv   = ($urandom % 4) == 0;
            ls   = 3'($urandom % 8);
            lsel = (($urandom % 4) == 0) ? 16'($urandom % 4) : 16'($urandom);
            lb   = $urandom;
            ll   = (($urandom % 2) == 0) ? 32'hFFFF_FFFF : ($urandom % 32'h1_0000);
            case ($urandom % 3)
                0:       lt = 4'h2;
                1:       lt = 4'hA;
                default: lt = 4'($urandom);
            endcase
            rv = ($urandom % 8) != 0;
            rk = 2'($urandom);
            ro = ($urandom % 3) == 0;
            oi = 3'($urandom % 8);
            rw = 1'($urandom);
            s  = seg_of(rk, ro, oi);
            case ($urandom % 4)
                0:       off = (s < 3'd6) ? m_limit[s] : 32'd0;
                1:       off = (s < 3'd6) ? m_limit[s] + 32'd1 : 32'd1;
                2:       off = $urandom % 32'h100;
                default: off = $urandom;
            endcase
            step(lv, ls, lsel, lb, ll, lt, rv, rk, ro, oi, off, rw, "R9");
        end

        finish_run();
    end

endmodule